// File: doc/BRIEF.md
# Store Buffer with Per-Byte Load Forwarding

This block is a small in-order queue placed between a pipeline's memory stage and a memory write port. In a single cycle the pipeline hands it a store: an aligned block address, a data vector covering the whole block, a byte-enable mask, and a flag saying whether the store is still speculative. The pipeline then continues without waiting for memory. Committed entries leave the queue oldest-first over a valid/ready write port, in the background and independently of new stores.

A combinational lookup port serves loads that lie within one aligned block. For every byte of the block, the youngest pending store that covers that byte supplies it. Bytes that no store covers come from cache data that the caller presents alongside the load address. A per-byte hit mask reports which bytes came from the queue. A squash input discards every entry that is still speculative, so none of them is ever written. A commit input promotes the oldest speculative entry. A full output stalls the pipeline. A fence request is tracked by a three-state machine. In FS_IDLE a request moves it to FS_WAIT while older entries remain, or straight to FS_DONE when nothing is pending. FS_WAIT moves to FS_DONE once every entry that was present at the request has drained or been discarded. FS_DONE returns to FS_IDLE after one cycle.

Top module: `store_buffer`

## Requirements
- R1: `st_full` is high exactly when DEPTH entries are held. A store offered while `st_full` is high is dropped and leaves no trace in the queue or on the lookup port. Any other store offered outside a squash cycle is accepted at the next clock edge.
- R2: Every entry holds its block address, its full data vector and its byte-enable mask. When the entry drains, these appear unchanged on `mem_addr`, `mem_data` and `mem_be`.
- R3: Bit b of `ld_hit` is 1 exactly when some held entry has a block address equal to `ld_addr` and has bit b of its enable mask set. Bit b corresponds to data bits 8b+7 down to 8b.
- R4: Each byte of `ld_data` comes from the youngest held entry that hits on that byte. Where no entry hits, the byte comes from `ld_cache`. One result can therefore mix bytes from several entries and from the cache.
- R5: `mem_valid` is high exactly when the oldest entry is committed. One entry leaves per cycle in which both `mem_valid` and `mem_ready` are high, always the oldest. While `mem_ready` is low, the presented entry holds steady.
- R6: A `commit` pulse marks the oldest speculative entry as committed, and is ignored if no entry is speculative. A store presented with `st_spec`=0 is held as committed only if every older entry is committed after this cycle's commit. Otherwise it is held as speculative. Speculative entries never drain.
- R7: A `squash` pulse removes every speculative entry, and none of them ever appears on the write port. A store or commit offered in the same cycle as the squash is ignored. A drain handshake in that cycle still completes.
- R8: A `fence_req` sampled in FS_IDLE causes `fence_done` to be high for exactly one cycle. That cycle comes once all entries present at the request have drained or been squashed, or one cycle after the request if none remain. A request made outside FS_IDLE is ignored.
- R9: After reset the queue is empty: `st_full`, `mem_valid`, `fence_done` and `ld_hit` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store offered this cycle |
| st_addr | input | ADDR_W | Aligned block address of the store |
| st_data | input | 8*BLK_BYTES | Store data for the whole block |
| st_be | input | BLK_BYTES | Byte-enable mask of the store |
| st_spec | input | 1 | 1 = store is speculative |
| st_full | output | 1 | Queue full, stall the pipeline |
| commit | input | 1 | Commit the oldest speculative entry |
| squash | input | 1 | Discard all speculative entries |
| fence_req | input | 1 | Fence request pulse |
| fence_done | output | 1 | One-cycle fence completion pulse |
| mem_valid | output | 1 | Head entry offered to memory |
| mem_ready | input | 1 | Memory accepts the offered entry |
| mem_addr | output | ADDR_W | Block address of the drained entry |
| mem_data | output | 8*BLK_BYTES | Data of the drained entry |
| mem_be | output | BLK_BYTES | Byte enables of the drained entry |
| ld_addr | input | ADDR_W | Block address of the load |
| ld_cache | input | 8*BLK_BYTES | Cache data for the load block |
| ld_data | output | 8*BLK_BYTES | Merged load result |
| ld_hit | output | BLK_BYTES | Per-byte forwarded mask |

## Verification
The occupancy, commit count and pointers are all visible at the ports within a cycle. A wrong committed count shows at once as `mem_valid` rising for a speculative head, or staying low for a committed one. A misplaced pointer or a lost entry shows in the very next load lookup as a wrong `ld_hit` bit or a stale byte, and later as a wrong drain order. An error in the fence pending counter shows as `fence_done` firing too early or too late relative to the model's drain count. The bench keeps its own queue, compares every output on every cycle, and concentrates addresses on four blocks so that overlaps and youngest-wins cases occur constantly.

// File: rtl/sb_pkg.sv
package sb_pkg;
    typedef enum logic [1:0] {
        FS_IDLE,
        FS_WAIT,
        FS_DONE
    } fence_st_t;
endpackage

// File: rtl/sb_queue.sv
module sb_queue #(
    parameter int DEPTH   = 8,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 64,
    parameter int BE_W    = 8,
    parameter int PW      = 3,
    parameter int CW      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enq,
    input  logic              enq_spec,
    input  logic [ADDR_W-1:0] enq_addr,
    input  logic [DATA_W-1:0] enq_data,
    input  logic [BE_W-1:0]   enq_be,
    input  logic              commit,
    input  logic              squash,
    input  logic              deq,
    output logic [PW-1:0]     head,
    output logic [CW-1:0]     cnt,
    output logic [CW-1:0]     ncom,
    output logic [CW-1:0]     cnt_nxt,
    output logic [ADDR_W-1:0] e_addr [DEPTH],
    output logic [DATA_W-1:0] e_data [DEPTH],
    output logic [BE_W-1:0]   e_be   [DEPTH]
);
    localparam int SW = PW + CW + 1;

    logic [PW-1:0] head_q, tail_q, head_n, tail_n;
    logic [CW-1:0] cnt_q, ncom_q, cnt_n, ncom_n;
    logic          com_add, enq_com;

    function automatic logic [PW-1:0] wrap_add(input logic [PW-1:0] p, input logic [CW-1:0] n);
        logic [SW-1:0] s;
        s = SW'(p) + SW'(n);
        if (s >= SW'(DEPTH)) s = s - SW'(DEPTH);
        return s[PW-1:0];
    endfunction

    assign com_add = commit && !squash && (ncom_q < cnt_q);
    assign enq_com = enq && !enq_spec && ((ncom_q + CW'(com_add)) == cnt_q);

    always_comb begin
        head_n = deq ? wrap_add(head_q, CW'(1)) : head_q;
        if (squash) begin
            cnt_n  = ncom_q - CW'(deq);
            ncom_n = ncom_q - CW'(deq);
            tail_n = wrap_add(head_q, ncom_q);
        end else begin
            cnt_n  = cnt_q + CW'(enq) - CW'(deq);
            ncom_n = ncom_q + CW'(com_add) + CW'(enq_com) - CW'(deq);
            tail_n = enq ? wrap_add(tail_q, CW'(1)) : tail_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
            ncom_q <= '0;
        end else begin
            head_q <= head_n;
            tail_q <= tail_n;
            cnt_q  <= cnt_n;
            ncom_q <= ncom_n;
        end
    end

    always_ff @(posedge clk) begin
        if (enq) begin
            e_addr[tail_q] <= enq_addr;
            e_data[tail_q] <= enq_data;
            e_be[tail_q]   <= enq_be;
        end
    end

    assign head    = head_q;
    assign cnt     = cnt_q;
    assign ncom    = ncom_q;
    assign cnt_nxt = cnt_n;

    // R6: committed entries always form a prefix of the held entries
    p_ncom_le_cnt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ncom_q <= cnt_q);
    // R1: occupancy never exceeds the depth
    p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));
    // R5: only committed entries may be dequeued
    p_deq_committed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        deq |-> (ncom_q != '0));
endmodule

// File: rtl/sb_fwd.sv
module sb_fwd #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int BE_W   = 8,
    parameter int DATA_W = 64,
    parameter int PW     = 3,
    parameter int CW     = 4
) (
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_cache,
    input  logic [PW-1:0]     head,
    input  logic [CW-1:0]     cnt,
    input  logic [ADDR_W-1:0] e_addr [DEPTH],
    input  logic [DATA_W-1:0] e_data [DEPTH],
    input  logic [BE_W-1:0]   e_be   [DEPTH],
    output logic [DATA_W-1:0] ld_data,
    output logic [BE_W-1:0]   ld_hit
);
    localparam int IW = PW + 1;

    // Scan from oldest to youngest; a later match overrides an earlier one.
    always_comb begin
        ld_data = ld_cache;
        ld_hit  = '0;
        for (int k = 0; k < DEPTH; k++) begin
            logic [IW-1:0] s;
            s = IW'(head) + IW'(k);
            if (s >= IW'(DEPTH)) s = s - IW'(DEPTH);
            if ((CW'(k) < cnt) && (e_addr[s[PW-1:0]] == ld_addr)) begin
                for (int b = 0; b < BE_W; b++) begin
                    if (e_be[s[PW-1:0]][b]) begin
                        ld_hit[b]         = 1'b1;
                        ld_data[8*b +: 8] = e_data[s[PW-1:0]][8*b +: 8];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/sb_fence.sv
module sb_fence #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fence_req,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] cnt_nxt,
    input  logic          deq,
    output logic          fence_done
);
    import sb_pkg::*;

    fence_st_t     st_q, st_n;
    logic [CW-1:0] pend_q, base, rem;

    always_comb begin
        base = (st_q == FS_IDLE) ? cnt : pend_q;
        rem  = base - CW'(deq);
        if (rem > cnt_nxt) rem = cnt_nxt;
        st_n = st_q;
        unique case (st_q)
            FS_IDLE: if (fence_req) st_n = (rem == '0) ? FS_DONE : FS_WAIT;
            FS_WAIT: st_n = (rem == '0) ? FS_DONE : FS_WAIT;
            FS_DONE: st_n = FS_IDLE;
            default: st_n = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= FS_IDLE;
            pend_q <= '0;
        end else begin
            st_q <= st_n;
            if (st_n == FS_WAIT) pend_q <= rem;
        end
    end

    always_comb begin
        fence_done = (st_q == FS_DONE);
    end

    // R8: completion is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fence_done |=> !fence_done);
    // R8: a waiting fence never finishes while its pending count is above zero and nothing leaves
    p_wait_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FS_WAIT && !deq && cnt_nxt >= pend_q) |=> !fence_done);
endmodule

// File: rtl/store_buffer.sv
module store_buffer #(
    parameter int DEPTH     = 8,
    parameter int BLK_BYTES = 8,
    parameter int ADDR_W    = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   st_valid,
    input  logic [ADDR_W-1:0]      st_addr,
    input  logic [8*BLK_BYTES-1:0] st_data,
    input  logic [BLK_BYTES-1:0]   st_be,
    input  logic                   st_spec,
    output logic                   st_full,
    input  logic                   commit,
    input  logic                   squash,
    input  logic                   fence_req,
    output logic                   fence_done,
    output logic                   mem_valid,
    input  logic                   mem_ready,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic [8*BLK_BYTES-1:0] mem_data,
    output logic [BLK_BYTES-1:0]   mem_be,
    input  logic [ADDR_W-1:0]      ld_addr,
    input  logic [8*BLK_BYTES-1:0] ld_cache,
    output logic [8*BLK_BYTES-1:0] ld_data,
    output logic [BLK_BYTES-1:0]   ld_hit
);
    localparam int DATA_W = 8 * BLK_BYTES;
    localparam int PW     = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW     = $clog2(DEPTH + 1);

    logic [PW-1:0]     head;
    logic [CW-1:0]     cnt, ncom, cnt_nxt;
    logic [ADDR_W-1:0] e_addr [DEPTH];
    logic [DATA_W-1:0] e_data [DEPTH];
    logic [BLK_BYTES-1:0] e_be [DEPTH];
    logic              enq, deq;

    assign st_full   = (cnt == CW'(DEPTH));
    assign enq       = st_valid && !st_full && !squash;
    assign mem_valid = (ncom != '0);
    assign deq       = mem_valid && mem_ready;
    assign mem_addr  = e_addr[head];
    assign mem_data  = e_data[head];
    assign mem_be    = e_be[head];

    sb_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BLK_BYTES),
               .PW(PW), .CW(CW)) u_queue (
        .clk(clk), .rst_n(rst_n), .enq(enq), .enq_spec(st_spec),
        .enq_addr(st_addr), .enq_data(st_data), .enq_be(st_be),
        .commit(commit), .squash(squash), .deq(deq),
        .head(head), .cnt(cnt), .ncom(ncom), .cnt_nxt(cnt_nxt),
        .e_addr(e_addr), .e_data(e_data), .e_be(e_be)
    );

    sb_fwd #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .BE_W(BLK_BYTES), .DATA_W(DATA_W),
             .PW(PW), .CW(CW)) u_fwd (
        .ld_addr(ld_addr), .ld_cache(ld_cache), .head(head), .cnt(cnt),
        .e_addr(e_addr), .e_data(e_data), .e_be(e_be),
        .ld_data(ld_data), .ld_hit(ld_hit)
    );

    sb_fence #(.CW(CW)) u_fence (
        .clk(clk), .rst_n(rst_n), .fence_req(fence_req), .cnt(cnt),
        .cnt_nxt(cnt_nxt), .deq(deq), .fence_done(fence_done)
    );

    // R1: a store offered while full does not grow the queue
    p_full_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_full && st_valid) |=> (cnt <= $past(cnt)));
    // R5: the offered entry holds while memory stalls
    p_head_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                       && $stable(mem_data) && $stable(mem_be)));
    // R7: after a squash no speculative entry remains
    p_squash_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> (cnt == ncom));
    // R3: an empty queue forwards nothing
    p_empty_nohit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> (ld_hit == '0));
endmodule

// File: tb/store_buffer_test.sv
module store_buffer_test;
    localparam int DEPTH = 8;
    localparam int BB    = 8;
    localparam int AW    = 32;
    localparam int DW    = 8 * BB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          st_valid = 0, st_spec = 0, commit = 0, squash = 0, fence_req = 0, mem_ready = 0;
    logic [AW-1:0] st_addr = '0, ld_addr = '0, mem_addr;
    logic [DW-1:0] st_data = '0, ld_cache = '0, mem_data, ld_data;
    logic [BB-1:0] st_be = '0, mem_be, ld_hit;
    logic          st_full, fence_done, mem_valid;

    always #5 clk = ~clk;

    store_buffer #(.DEPTH(DEPTH), .BLK_BYTES(BB), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
        .st_data(st_data), .st_be(st_be), .st_spec(st_spec), .st_full(st_full),
        .commit(commit), .squash(squash), .fence_req(fence_req), .fence_done(fence_done),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_be(mem_be), .ld_addr(ld_addr), .ld_cache(ld_cache),
        .ld_data(ld_data), .ld_hit(ld_hit)
    );

    typedef struct packed {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic [BB-1:0] be;
        logic          com;
    } ment_t;

    ment_t mq[$];
    int    fst = 0, fpend = 0;
    int    total = 0, bad = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // reference model, advanced at each rising edge
    always @(posedge clk) begin
        int  osz, base, np;
        bit  fire, allc;
        ment_t ne;
        if (!rst_n) begin
            mq.delete();
            fst = 0;
            fpend = 0;
        end else begin
            osz  = mq.size();
            fire = (osz > 0) && mq[0].com && mem_ready;
            if (fire) void'(mq.pop_front());
            if (squash) begin
                while (mq.size() > 0 && !mq[mq.size()-1].com) void'(mq.pop_back());
            end else begin
                if (commit) begin
                    for (int i = 0; i < mq.size(); i++)
                        if (!mq[i].com) begin mq[i].com = 1'b1; break; end
                end
                if (st_valid && osz < DEPTH) begin
                    allc = 1'b1;
                    foreach (mq[i]) if (!mq[i].com) allc = 1'b0;
                    ne.a = st_addr; ne.d = st_data; ne.be = st_be;
                    ne.com = !st_spec && allc;
                    mq.push_back(ne);
                end
            end
            base = (fst == 0) ? osz : fpend;
            if ((fst == 0 && fence_req) || fst == 1) begin
                np = base - (fire ? 1 : 0);
                if (np > mq.size()) np = mq.size();
                if (np == 0) fst = 2;
                else begin fst = 1; fpend = np; end
            end else if (fst == 2) begin
                fst = 0;
            end
        end
    end

    task automatic compare();
        logic [BB-1:0] eh;
        logic [DW-1:0] ed;
        bit ev;
        eh = '0;
        ed = ld_cache;
        foreach (mq[i]) if (mq[i].a == ld_addr)
            for (int b = 0; b < BB; b++) if (mq[i].be[b]) begin
                eh[b] = 1'b1;
                ed[8*b +: 8] = mq[i].d[8*b +: 8];
            end
        ev = (mq.size() > 0) && mq[0].com;
        chk(st_full == (mq.size() == DEPTH), "R1", "st_full", DW'(st_full), DW'(mq.size() == DEPTH));
        chk(mem_valid == ev, "R5", "mem_valid", DW'(mem_valid), DW'(ev));
        if (ev) begin
            chk(mem_addr == mq[0].a, "R2", "mem_addr", DW'(mem_addr), DW'(mq[0].a));
            chk(mem_data == mq[0].d, "R2", "mem_data", mem_data, mq[0].d);
            chk(mem_be == mq[0].be, "R2", "mem_be", DW'(mem_be), DW'(mq[0].be));
        end
        chk(ld_hit == eh, "R3", "ld_hit", DW'(ld_hit), DW'(eh));
        chk(ld_data == ed, "R4", "ld_data", ld_data, ed);
        chk(fence_done == (fst == 2), "R8", "fence_done", DW'(fence_done), DW'(fst == 2));
    endtask

    task automatic step();
        #1 compare();
        @(negedge clk);
        st_valid = 0; commit = 0; squash = 0; fence_req = 0;
    endtask

    task automatic put(input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic [BB-1:0] be, input logic spec);
        st_valid = 1; st_addr = a; st_data = d; st_be = be; st_spec = spec;
        step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit seen;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R9 reset state
        chk(!st_full, "R9", "st_full", DW'(st_full), 0);
        chk(!mem_valid, "R9", "mem_valid", DW'(mem_valid), 0);
        chk(!fence_done, "R9", "fence_done", DW'(fence_done), 0);
        chk(ld_hit == '0, "R9", "ld_hit", DW'(ld_hit), 0);
        @(negedge clk);

        // R3/R4 stitching of two overlapping speculative stores with cache bytes
        put(5, 64'h1111_1111_1111_1111, 8'h0F, 1);
        put(5, 64'h2222_2222_2222_2222, 8'h3C, 1);
        ld_addr = 5; ld_cache = {8{8'hAA}};
        #1;
        chk(ld_hit == 8'h3F, "R3", "stitch hit", DW'(ld_hit), 64'h3F);
        chk(ld_data == 64'hAAAA_2222_2222_1111, "R4", "youngest wins", ld_data, 64'hAAAA_2222_2222_1111);
        chk(!mem_valid, "R6", "spec no drain", DW'(mem_valid), 0);
        step();

        // R6 commit oldest, R7 squash the rest
        commit = 1; step();
        chk(mem_valid, "R6", "committed head offered", DW'(mem_valid), 1);
        squash = 1; step();
        #1 chk(ld_hit == 8'h0F, "R7", "squashed bytes gone", DW'(ld_hit), 64'h0F);
        mem_ready = 1; step(); step();
        chk(!mem_valid, "R7", "nothing left to drain", DW'(mem_valid), 0);

        // R1 fill, then drop an extra store
        mem_ready = 0;
        for (int i = 0; i <= DEPTH; i++) put(AW'(16 + i), {8{8'(i)}}, 8'hFF, 0);
        ld_addr = AW'(16 + DEPTH);
        #1;
        chk(st_full, "R1", "full", DW'(st_full), 1);
        chk(ld_hit == '0, "R1", "dropped store absent", DW'(ld_hit), 0);
        step();

        // R8 fence over a stalling memory
        fence_req = 1; step();
        put(40, '1, 8'h01, 0);
        seen = 0;
        for (int c = 0; c < 80 && !seen; c++) begin
            mem_ready = c[0];
            if (fence_done) seen = 1;
            step();
        end
        chk(seen, "R8", "fence completes", DW'(seen), 1);

        // mixed traffic, compared every cycle
        for (int c = 0; c < 4000; c++) begin
            st_valid  = ($urandom % 2) == 0;
            st_addr   = AW'($urandom % 4);
            st_data   = {$urandom, $urandom};
            st_be     = 8'($urandom);
            st_spec   = ($urandom % 3) == 0;
            commit    = ($urandom % 3) == 0;
            squash    = ($urandom % 23) == 0;
            fence_req = ($urandom % 17) == 0;
            mem_ready = ($urandom % 3) != 0;
            ld_addr   = AW'($urandom % 4);
            ld_cache  = {$urandom, $urandom};
            step();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule